// File: doc/BRIEF.md
# Software Command Address-Sequence Detector

This block watches the accesses on a byte-wide SRAM-style bus and looks for a command hidden in a run of ordinary reads. Five fixed read addresses form a shared opening. A sixth read then chooses the command: one address asks for a nonvolatile store, another asks for a nonvolatile recall. When the run completes, the detector raises a request pulse for one clock cycle. The store or recall engine downstream consumes this pulse.

The detector only observes the bus. Reads that form part of a command still return normal array data, and no access is ever stalled. A write anywhere in the run cancels it. A read at an address that does not fit the run also cancels it, unless that address is the opening address, in which case a new attempt starts from it. While a nonvolatile operation is running, all accesses are ignored and any progress is cleared.

Top module: `swcmd_seq_detect`

## Requirements
- R1: During and directly after reset, `store_req` and `recall_req` are low and no partial run is remembered.
- R2: A read is taken as the next step only when its address equals the expected entry of the opening 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order. Cycles with neither strobe leave the progress unchanged.
- R3: After the five opening reads, a read at 0x0FC0 makes `store_req` high for exactly the one cycle that follows the clock edge sampling that read. This happens regardless of any earlier array writes.
- R4: After the five opening reads, a read at 0x0C63 makes `recall_req` high for exactly the one cycle that follows the clock edge sampling that read.
- R5: A cycle with `wr_en` high, including one where `rd_en` is also high, issues no request and returns the detector to the start.
- R6: A read at any address other than the expected one returns the detector to the start. If that address is 0x0E38, the read counts as the first step of a new run.
- R7: The two request outputs are never high together, and neither stays high for two consecutive cycles.
- R8: While `nv_busy` is high, strobes are ignored, no request is issued, and all progress is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nv_busy | input | 1 | High while a nonvolatile operation is in progress |
| rd_en | input | 1 | Read strobe qualifier, one access per high cycle |
| wr_en | input | 1 | Write strobe qualifier, one access per high cycle |
| addr | input | 15 | Access address |
| store_req | output | 1 | One-cycle store request pulse |
| recall_req | output | 1 | One-cycle recall request pulse |

## Verification
Each access is sampled on one rising edge. Its only visible effect, a request pulse, is due in the cycle right after that same edge; progress through a run shows up only through a later pulse. The bench applies every access at a falling edge and compares both outputs at the next falling edge against a bench model. The model advances once per access, so every comparison lines up with the one clock of latency. Randomized runs that mostly follow the command path are mixed with directed runs for aborts, restarts and busy periods.

// File: rtl/swcmd_seq_detect.sv
module swcmd_seq_detect #(
  parameter int AW = 15,
  parameter logic [AW-1:0] SEQ0 = 15'h0E38,
  parameter logic [AW-1:0] SEQ1 = 15'h31C7,
  parameter logic [AW-1:0] SEQ2 = 15'h03E0,
  parameter logic [AW-1:0] SEQ3 = 15'h3C1F,
  parameter logic [AW-1:0] SEQ4 = 15'h303F,
  parameter logic [AW-1:0] STORE_A = 15'h0FC0,
  parameter logic [AW-1:0] RECALL_A = 15'h0C63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_busy,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic          store_req,
  output logic          recall_req
);
  localparam int LAST = 5;

  logic [2:0]    step;
  logic [AW-1:0] want;

  always_comb begin
    case (step)
      3'd0:    want = SEQ0;
      3'd1:    want = SEQ1;
      3'd2:    want = SEQ2;
      3'd3:    want = SEQ3;
      default: want = SEQ4;
    endcase
  end

  wire rd_ok   = rd_en && !wr_en && !nv_busy;
  wire at_end  = (step == 3'(LAST));
  wire advance = rd_ok && !at_end && (addr == want);
  wire fire_st = rd_ok && at_end && (addr == STORE_A);
  wire fire_rc = rd_ok && at_end && (addr == RECALL_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= fire_st;
      recall_req <= fire_rc;
      if (nv_busy || wr_en)
        step <= '0;
      else if (rd_en) begin
        if (advance)
          step <= step + 3'd1;
        else if (fire_st || fire_rc)
          step <= '0;
        else
          step <= (addr == SEQ0) ? 3'd1 : 3'd0;
      end
    end
  end
endmodule

module swcmd_seq_detect_chk #(
  parameter int AW = 15,
  parameter logic [AW-1:0] STORE_A = 15'h0FC0,
  parameter logic [AW-1:0] RECALL_A = 15'h0C63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nv_busy,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          store_req,
  input logic          recall_req
);
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_req && recall_req));
  assert_store_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |=> !store_req);
  assert_recall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |=> !recall_req);
  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> !store_req && !recall_req);
  assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !store_req && !recall_req);
  assert_store_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && !nv_busy && addr != STORE_A |=> !store_req);
  assert_recall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && !nv_busy && addr != RECALL_A |=> !recall_req);
endmodule

bind swcmd_seq_detect swcmd_seq_detect_chk #(.AW(AW), .STORE_A(STORE_A), .RECALL_A(RECALL_A)) chk_i (
  .clk(clk), .rst_n(rst_n), .nv_busy(nv_busy), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .store_req(store_req), .recall_req(recall_req));

// File: tb/swcmd_seq_detect_tb.sv
`timescale 1ns/1ps
module swcmd_seq_detect_tb_top;
  localparam logic [14:0] ST = 15'h0FC0, RC = 15'h0C63;

  logic clk = 1'b0, rst_n = 1'b0, nv_busy = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic store_req, recall_req;
  int checks = 0, fails = 0, mstep = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swcmd_seq_detect dut_i (.clk(clk), .rst_n(rst_n), .nv_busy(nv_busy), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .store_req(store_req), .recall_req(recall_req));

  function automatic logic [14:0] seq_addr(int s);
    case (s)
      0: return 15'h0E38;
      1: return 15'h31C7;
      2: return 15'h03E0;
      3: return 15'h3C1F;
      default: return 15'h303F;
    endcase
  endfunction

  task automatic check(string tag, logic st, logic rc, logic est, logic erc);
    checks++;
    if (st !== est || rc !== erc) begin
      fails++;
      $display("FAIL %s: store/recall actual %b/%b expected %b/%b", tag, st, rc, est, erc);
    end
  endtask

  task automatic cyc(bit rd, bit wr, bit bsy, logic [14:0] a);
    logic est = 0, erc = 0;
    string tag = "R2";
    if (bsy) begin mstep = 0; tag = "R8"; end
    else if (wr) begin mstep = 0; tag = "R5"; end
    else if (rd) begin
      if (mstep == 5) begin
        if (a == ST) begin est = 1; mstep = 0; tag = "R3"; end
        else if (a == RC) begin erc = 1; mstep = 0; tag = "R4"; end
        else begin mstep = (a == seq_addr(0)) ? 1 : 0; tag = "R6"; end
      end else if (a == seq_addr(mstep)) mstep++;
      else begin mstep = (a == seq_addr(0)) ? 1 : 0; tag = "R6"; end
    end
    rd_en = rd; wr_en = wr; nv_busy = bsy; addr = a;
    @(posedge clk); @(negedge clk);
    check(tag, store_req, recall_req, est, erc);
  endtask

  task automatic prefix(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, seq_addr(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", store_req, recall_req, 0, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, '0);
    // R3 and R4 plain commands
    prefix(5); cyc(1, 0, 0, ST);
    cyc(0, 0, 0, '0);
    prefix(5); cyc(1, 0, 0, RC);
    // R2 idle gaps do not disturb progress
    prefix(2); cyc(0, 0, 0, 15'h1111); cyc(0, 0, 0, '0); for (int i = 2; i < 5; i++) cyc(1, 0, 0, seq_addr(i));
    cyc(1, 0, 0, ST);
    // R5 write mid-run, and write with read at step 6
    prefix(3); cyc(0, 1, 0, seq_addr(3)); cyc(1, 0, 0, seq_addr(3)); cyc(1, 0, 0, seq_addr(4)); cyc(1, 0, 0, ST);
    prefix(5); cyc(1, 1, 0, ST); cyc(1, 0, 0, ST);
    // R6 restart on opening address, wrong sixth address
    prefix(3); cyc(1, 0, 0, seq_addr(0)); for (int i = 1; i < 5; i++) cyc(1, 0, 0, seq_addr(i)); cyc(1, 0, 0, RC);
    prefix(5); cyc(1, 0, 0, 15'h0FC1); cyc(1, 0, 0, RC);
    prefix(5); cyc(1, 0, 0, seq_addr(0)); for (int i = 1; i < 5; i++) cyc(1, 0, 0, seq_addr(i)); cyc(1, 0, 0, ST);
    // R8 busy clears progress and blocks a sixth read
    prefix(4); cyc(1, 0, 1, seq_addr(4)); cyc(1, 0, 0, seq_addr(4)); cyc(1, 0, 0, ST);
    prefix(5); cyc(1, 0, 1, RC); cyc(1, 0, 0, RC);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(99);
      if (r < 70) begin
        if (mstep == 5) cyc(1, 0, 0, ($urandom_range(1) != 0) ? ST : RC);
        else cyc(1, 0, 0, seq_addr(mstep));
      end else if (r < 78) cyc(0, 0, 0, 15'($urandom));
      else if (r < 85) cyc($urandom_range(1) != 0, 1, 0, 15'($urandom));
      else if (r < 90) cyc(1, 0, 0, seq_addr(0));
      else if (r < 96) cyc(1, 0, 0, 15'($urandom));
      else cyc($urandom_range(1) != 0, 0, 1, ($urandom_range(1) != 0) ? ST : 15'($urandom));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule